// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the 64-byte type-0 configuration header of one PCI function and serves configuration reads and writes of one, two or four bytes. A request carries a byte offset, a byte count, a write flag and LSB-aligned write data. Each access runs through a small state machine that accepts it, applies the write and captures the read data and error flag at once, then returns a one-cycle response after a fixed, parameterised latency. Every field decides for itself whether a write is stored, dropped without complaint, or answered with an error.

Six base address registers support size probing. Writing all ones to one of them returns the inverted size mask with the type bits kept. A write with a non-zero address part also moves a decode base that the block exports, together with each BAR's size. A combinational address matcher compares an incoming address against those windows and reports a one-hot BAR index. Identification values, initial field contents, BAR sizes and legacy flags are all module parameters loaded at reset.

The access state machine has three states: `ST_IDLE`, `ST_WAIT` and `ST_RESP`. An accepted request moves `ST_IDLE` to `ST_RESP` when the latency is 1, and `ST_IDLE` to `ST_WAIT` otherwise. `ST_WAIT` moves to `ST_RESP` when its latency count is reached. `ST_RESP` always returns to `ST_IDLE` after one cycle.

Top module: `cfg_header_regfile`

## Requirements
- R1: In the 4-byte read at offset 0x00, the vendor ID sits in bits 15:0 and the device ID in bits 31:16. The other standard header offsets are: command 0x04, status 0x06, revision 0x08, programming interface 0x09, subclass 0x0A, class 0x0B, cache-line size 0x0C, latency timer 0x0D, header type 0x0E, self-test 0x0F, BARs 0x10+4*i, card-info pointer 0x28, subsystem vendor 0x2C, subsystem ID 0x2E, ROM BAR 0x30, reserved zero 0x34-0x3B, interrupt line 0x3C, interrupt pin 0x3D, minimum grant 0x3E, maximum latency 0x3F. A read of size 1, 2 or 4 at offset N returns the bytes from N upward, little-endian and LSB-aligned, with zero for any byte beyond 0x3F. After reset every field holds its parameter value.
- R2: Any access at offset 0x40 or above sets the error flag, returns zero read data and changes no state.
- R3: A request size other than 1, 2 or 4 sets the error flag, returns zero data and changes no state.
- R4: The response-valid pulse lasts one cycle. It is high after the RSP_LAT-th rising edge, counting the edge that accepts the request as the first. Ready is low from acceptance until the response has been given.
- R5: A byte write stores into the interrupt line (0x3C), the cache-line size (0x0C) and the latency timer (0x0D). It is dropped without error at 0x08, 0x0B, 0x3D, 0x3E and 0x3F. At any other offset it sets the error flag.
- R6: A 16-bit write stores the command at 0x04 and the status at 0x06, and stores its low byte into the cache-line size at 0x0C. At any other offset it sets the error flag.
- R7: A 32-bit write at 0x04 stores bits 15:0 into the command and leaves the status alone. A 32-bit write to an offset other than 0x04, a BAR or the ROM BAR is dropped without error.
- R8: A 32-bit write of 0xFFFFFFFF to a non-legacy BAR stores ~(size-1) in the bits above its type field and keeps the old type field. The type field is the low 2 bits when the old bit 0 is 1 (IO) and the low 4 bits otherwise.
- R9: Any other 32-bit BAR write stores the value with the type field replaced by the old type field. If the address part is non-zero it becomes the BAR's decode base; if it is zero the decode base is left unchanged.
- R10: A BAR whose legacy flag is set always reads zero and ignores writes without error.
- R11: A 32-bit write of 0xFFFFFFFE to the ROM BAR stores 0xFFFFFFFF; any other value is stored as written.
- R12: The hit output is one-hot on the lowest BAR index whose window [base, base+size) contains the hit address, provided the BAR is non-legacy and both its decode base and its size are non-zero; otherwise the output is zero. A new decode base is used from the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | 8 | Byte offset into the configuration space |
| req_size | input | 3 | Byte count of the access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data, LSB-aligned |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, LSB-aligned, zero on error |
| rsp_error | output | 1 | Access rejected |
| hit_addr | input | 32 | Address to compare against the BAR windows |
| hit_onehot | output | 6 | One-hot index of the matching BAR |
| bar_base_flat | output | 192 | Decode base of each BAR, BAR i in bits 32*i+31:32*i |
| bar_size_flat | output | 192 | Window size of each BAR, same packing |

## Verification
The cycle in which a BAR write is accepted is also a cycle in which the address matcher is answering. The block must give the old window during that cycle and the new one after the edge. The bench drives a BAR write and, in the same cycle, a hit address inside the window being written. It checks the hit output just before the accepting edge against the previous decode state, and just after the edge against the updated one. The random phase also re-aims the hit address at the model's windows after every access, so that decode changes from probes, zero writes and type-preserving writes are all judged against the bench model.

// File: rtl/cfghdr_pkg.sv
package cfghdr_pkg;

    localparam int NUM_BARS  = 6;
    localparam int HDR_BYTES = 64;
    localparam int HDR_WORDS = HDR_BYTES / 4;
    localparam int BAR_WORD0 = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } acc_state_t;

    localparam logic [7:0] OFF_CMD   = 8'h04;
    localparam logic [7:0] OFF_STAT  = 8'h06;
    localparam logic [7:0] OFF_REV   = 8'h08;
    localparam logic [7:0] OFF_CLASS = 8'h0B;
    localparam logic [7:0] OFF_CLS   = 8'h0C;
    localparam logic [7:0] OFF_LAT   = 8'h0D;
    localparam logic [7:0] OFF_BAR0  = 8'h10;
    localparam logic [7:0] OFF_ROM   = 8'h30;
    localparam logic [7:0] OFF_INTL  = 8'h3C;
    localparam logic [7:0] OFF_INTP  = 8'h3D;
    localparam logic [7:0] OFF_MING  = 8'h3E;
    localparam logic [7:0] OFF_MAXL  = 8'h3F;

    localparam logic [31:0] ROM_PROBE_IN  = 32'hFFFF_FFFE;
    localparam logic [31:0] ROM_PROBE_OUT = 32'hFFFF_FFFF;
    localparam logic [31:0] BAR_PROBE     = 32'hFFFF_FFFF;

    typedef struct packed {
        logic                intl;
        logic                cls;
        logic                lat;
        logic                cmd;
        logic                stat;
        logic                rom;
        logic [NUM_BARS-1:0] bar;
    } wr_sel_t;

    function automatic logic size_legal(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

endpackage

// File: rtl/cfg_access_fsm.sv
module cfg_access_fsm
    import cfghdr_pkg::*;
#(
    parameter int RSP_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic fire,
    output logic rsp_valid
);

    localparam int CW = (RSP_LAT < 2) ? 1 : $clog2(RSP_LAT + 1);
    localparam logic [CW-1:0] LAST = CW'(RSP_LAT - 1);

    acc_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        req_ready = 1'b0;
        fire      = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    fire  = 1'b1;
                    cnt_d = CW'(1);
                    if (RSP_LAT <= 1) state_d = ST_RESP;
                    else              state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (cnt_q == LAST) state_d = ST_RESP;
                else               cnt_d   = cnt_q + CW'(1);
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/cfg_wr_decode.sv
module cfg_wr_decode
    import cfghdr_pkg::*;
(
    input  logic       fire,
    input  logic       write,
    input  logic [7:0] off,
    input  logic [2:0] size,
    output wr_sel_t    sel,
    output logic       acc_err
);

    wr_sel_t sel_raw;

    always_comb begin
        sel_raw = '0;
        acc_err = 1'b0;
        if (!size_legal(size) || (off >= 8'(HDR_BYTES))) begin
            acc_err = 1'b1;
        end else if (write) begin
            case (size)
                3'd1: begin
                    case (off)
                        OFF_INTL: sel_raw.intl = 1'b1;
                        OFF_CLS:  sel_raw.cls  = 1'b1;
                        OFF_LAT:  sel_raw.lat  = 1'b1;
                        OFF_REV, OFF_CLASS, OFF_INTP, OFF_MING, OFF_MAXL: ;
                        default:  acc_err = 1'b1;
                    endcase
                end
                3'd2: begin
                    case (off)
                        OFF_CMD:  sel_raw.cmd  = 1'b1;
                        OFF_STAT: sel_raw.stat = 1'b1;
                        OFF_CLS:  sel_raw.cls  = 1'b1;
                        default:  acc_err = 1'b1;
                    endcase
                end
                default: begin
                    if (off == OFF_ROM) sel_raw.rom = 1'b1;
                    if (off == OFF_CMD) sel_raw.cmd = 1'b1;
                    for (int i = 0; i < NUM_BARS; i++) begin
                        if (off == OFF_BAR0 + 8'(4 * i)) sel_raw.bar[i] = 1'b1;
                    end
                end
            endcase
        end
        sel = (fire && write && !acc_err) ? sel_raw : '0;
    end

endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot #(
    parameter logic [31:0] INIT   = 32'h0,
    parameter logic [31:0] SIZE   = 32'h0,
    parameter bit          LEGACY = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] cfg_val,
    output logic [31:0] dec_base
);

    localparam logic [31:0] SIZE_MASK = ~(SIZE - 32'd1);

    generate
        if (LEGACY) begin : g_legacy
            logic unused_ok;
            assign unused_ok = ^{clk, rst_n, wr_en, wdata};
            assign cfg_val   = '0;
            assign dec_base  = '0;
        end else begin : g_live
            if ((SIZE != 32'd0) && ((SIZE & (SIZE - 32'd1)) != 32'd0)) begin : g_bad_size
                $error("BAR size must be zero or a power of two");
            end

            logic [31:0] bar_q, base_q;
            logic [31:0] type_mask, addr_part, next_val;

            always_comb begin
                type_mask = bar_q[0] ? 32'h0000_0003 : 32'h0000_000F;
                addr_part = (wdata == cfghdr_pkg::BAR_PROBE) ? SIZE_MASK
                                                             : (wdata & ~type_mask);
                next_val  = (addr_part & ~type_mask) | (bar_q & type_mask);
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bar_q  <= INIT;
                    base_q <= '0;
                end else if (wr_en) begin
                    bar_q <= next_val;
                    if ((wdata != cfghdr_pkg::BAR_PROBE) && (addr_part != 32'd0))
                        base_q <= addr_part;
                end
            end

            assign cfg_val  = bar_q;
            assign dec_base = base_q;
        end
    endgenerate

endmodule

// File: rtl/cfg_addr_match.sv
module cfg_addr_match
    import cfghdr_pkg::*;
#(
    parameter logic [NUM_BARS*32-1:0] BAR_SIZE   = '0,
    parameter logic [NUM_BARS-1:0]    BAR_LEGACY = '0
) (
    input  logic [31:0]            addr,
    input  logic [NUM_BARS*32-1:0] base_flat,
    output logic [NUM_BARS-1:0]    hit
);

    logic [NUM_BARS-1:0] in_win;

    generate
        for (genvar i = 0; i < NUM_BARS; i++) begin : g_win
            localparam logic [31:0] SZ = BAR_SIZE[32*i +: 32];
            logic [31:0] b;
            assign b = base_flat[32*i +: 32];
            assign in_win[i] = !BAR_LEGACY[i] && (SZ != 32'd0) && (b != 32'd0)
                             && (addr >= b) && ((addr - b) < SZ);
        end
    endgenerate

    always_comb begin
        hit = '0;
        for (int i = NUM_BARS - 1; i >= 0; i--) begin
            if (in_win[i]) hit = NUM_BARS'(1) << i;
        end
    end

endmodule

// File: rtl/cfg_header_regfile.sv
module cfg_header_regfile
    import cfghdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID  = 16'h7A31,
    parameter logic [15:0] CMD_INIT   = 16'h0000,
    parameter logic [15:0] STAT_INIT  = 16'h0210,
    parameter logic [7:0]  REV_ID     = 8'h05,
    parameter logic [7:0]  PROG_IF    = 8'h01,
    parameter logic [7:0]  SUB_CLASS  = 8'h06,
    parameter logic [7:0]  BASE_CLASS = 8'h02,
    parameter logic [7:0]  CLS_INIT   = 8'h00,
    parameter logic [7:0]  LAT_INIT   = 8'h00,
    parameter logic [7:0]  HDR_TYPE   = 8'h00,
    parameter logic [7:0]  BIST_INIT  = 8'h00,
    parameter logic [31:0] CIS_PTR    = 32'h0,
    parameter logic [15:0] SUBSYS_VID = 16'hABCD,
    parameter logic [15:0] SUBSYS_ID  = 16'h0102,
    parameter logic [31:0] ROM_INIT   = 32'h0,
    parameter logic [7:0]  INTL_INIT  = 8'h0B,
    parameter logic [7:0]  INT_PIN    = 8'h01,
    parameter logic [7:0]  MIN_GNT    = 8'h10,
    parameter logic [7:0]  MAX_LAT    = 8'h20,
    parameter logic [NUM_BARS*32-1:0] BAR_INIT =
        {32'h1, 32'h0, 32'h1F0, 32'h8, 32'h1, 32'h0},
    parameter logic [NUM_BARS*32-1:0] BAR_SIZE =
        {32'h40, 32'h0, 32'h8, 32'h0010_0000, 32'h100, 32'h1000},
    parameter logic [NUM_BARS-1:0] BAR_LEGACY = 6'b001000,
    parameter int RSP_LAT = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [7:0]             req_addr,
    input  logic [2:0]             req_size,
    input  logic                   req_write,
    input  logic [31:0]            req_wdata,
    output logic                   rsp_valid,
    output logic [31:0]            rsp_rdata,
    output logic                   rsp_error,
    input  logic [31:0]            hit_addr,
    output logic [NUM_BARS-1:0]    hit_onehot,
    output logic [NUM_BARS*32-1:0] bar_base_flat,
    output logic [NUM_BARS*32-1:0] bar_size_flat
);

    logic    fire;
    wr_sel_t sel;
    logic    acc_err;

    cfg_access_fsm #(.RSP_LAT(RSP_LAT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .fire      (fire),
        .rsp_valid (rsp_valid)
    );

    cfg_wr_decode u_dec (
        .fire    (fire),
        .write   (req_write),
        .off     (req_addr),
        .size    (req_size),
        .sel     (sel),
        .acc_err (acc_err)
    );

    logic [15:0] cmd_q, stat_q;
    logic [7:0]  cls_q, lat_q, intl_q;
    logic [31:0] rom_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_INIT;
            stat_q <= STAT_INIT;
            cls_q  <= CLS_INIT;
            lat_q  <= LAT_INIT;
            intl_q <= INTL_INIT;
            rom_q  <= ROM_INIT;
        end else begin
            if (sel.cmd)  cmd_q  <= req_wdata[15:0];
            if (sel.stat) stat_q <= req_wdata[15:0];
            if (sel.cls)  cls_q  <= req_wdata[7:0];
            if (sel.lat)  lat_q  <= req_wdata[7:0];
            if (sel.intl) intl_q <= req_wdata[7:0];
            if (sel.rom)  rom_q  <= (req_wdata == ROM_PROBE_IN) ? ROM_PROBE_OUT : req_wdata;
        end
    end

    logic [31:0] bar_val [NUM_BARS];

    generate
        for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
            cfg_bar_slot #(
                .INIT   (BAR_INIT[32*i +: 32]),
                .SIZE   (BAR_SIZE[32*i +: 32]),
                .LEGACY (BAR_LEGACY[i])
            ) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (sel.bar[i]),
                .wdata    (req_wdata),
                .cfg_val  (bar_val[i]),
                .dec_base (bar_base_flat[32*i +: 32])
            );
        end
    endgenerate

    assign bar_size_flat = BAR_SIZE;

    cfg_addr_match #(
        .BAR_SIZE   (BAR_SIZE),
        .BAR_LEGACY (BAR_LEGACY)
    ) u_match (
        .addr      (hit_addr),
        .base_flat (bar_base_flat),
        .hit       (hit_onehot)
    );

    logic [31:0] dw   [HDR_WORDS];
    logic [7:0]  hbyte [HDR_BYTES];

    always_comb begin
        for (int w = 0; w < HDR_WORDS; w++) dw[w] = '0;
        dw[0]  = {DEVICE_ID, VENDOR_ID};
        dw[1]  = {stat_q, cmd_q};
        dw[2]  = {BASE_CLASS, SUB_CLASS, PROG_IF, REV_ID};
        dw[3]  = {BIST_INIT, HDR_TYPE, lat_q, cls_q};
        for (int i = 0; i < NUM_BARS; i++) dw[BAR_WORD0 + i] = bar_val[i];
        dw[10] = CIS_PTR;
        dw[11] = {SUBSYS_ID, SUBSYS_VID};
        dw[12] = rom_q;
        dw[15] = {MAX_LAT, MIN_GNT, INT_PIN, intl_q};
    end

    generate
        for (genvar b = 0; b < HDR_BYTES; b++) begin : g_byte
            assign hbyte[b] = dw[b / 4][8 * (b % 4) +: 8];
        end
    endgenerate

    logic [31:0] rd_raw, rd_mask;

    always_comb begin
        rd_raw = '0;
        for (int k = 0; k < 4; k++) begin
            logic [8:0] idx;
            idx = {1'b0, req_addr} + 9'(k);
            if (idx < 9'(HDR_BYTES)) rd_raw[8*k +: 8] = hbyte[idx[5:0]];
        end
        case (req_size)
            3'd1:    rd_mask = 32'h0000_00FF;
            3'd2:    rd_mask = 32'h0000_FFFF;
            default: rd_mask = 32'hFFFF_FFFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_error <= 1'b0;
        end else if (fire) begin
            rsp_error <= acc_err;
            rsp_rdata <= (acc_err || req_write) ? 32'd0 : (rd_raw & rd_mask);
        end
    end

endmodule

// File: rtl/cfg_header_chk.sv
module cfg_header_chk
    import cfghdr_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic [7:0]             req_addr,
    input logic [2:0]             req_size,
    input logic                   req_write,
    input logic                   rsp_valid,
    input logic [31:0]            rsp_rdata,
    input logic                   rsp_error,
    input logic [31:0]            hit_addr,
    input logic [NUM_BARS-1:0]    hit_onehot,
    input logic [NUM_BARS*32-1:0] bar_base_flat,
    input logic [NUM_BARS*32-1:0] bar_size_flat
);

    logic [7:0] off_q;
    logic [2:0] size_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            size_q <= 3'd4;
        end else if (req_valid && req_ready) begin
            off_q  <= req_addr;
            size_q <= req_size;
        end
    end

    // R4
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R2
    high_off_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && off_q >= 8'(HDR_BYTES)) |-> (rsp_error && rsp_rdata == 32'd0));

    // R3
    bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !size_legal(size_q)) |-> rsp_error);

    // R12
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_onehot));

    // R9
    base_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bar_base_flat) |-> $past(req_valid && req_ready && req_write && req_size == 3'd4));

    generate
        for (genvar i = 0; i < NUM_BARS; i++) begin : g_win
            // R12
            hit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
                hit_onehot[i] |-> (bar_base_flat[32*i +: 32] != 32'd0
                    && hit_addr >= bar_base_flat[32*i +: 32]
                    && (hit_addr - bar_base_flat[32*i +: 32]) < bar_size_flat[32*i +: 32]));
        end
    endgenerate

endmodule

bind cfg_header_regfile cfg_header_chk u_chk (.*);

// File: tb/cfg_header_regfile_bench.sv
module cfg_header_regfile_bench;

    localparam int LAT = 3;
    localparam logic [6*32-1:0] B_INIT =
        {32'h1, 32'h0, 32'h1F0, 32'h8, 32'h1, 32'h0};
    localparam logic [6*32-1:0] B_SIZE =
        {32'h40, 32'h0, 32'h8, 32'h0010_0000, 32'h100, 32'h1000};
    localparam logic [5:0] B_LEG = 6'b001000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [2:0] req_size = 3'd4;
    logic [31:0] req_wdata = '0, hit_addr = '0;
    logic req_ready, rsp_valid, rsp_error;
    logic [31:0] rsp_rdata;
    logic [5:0] hit_onehot;
    logic [191:0] bar_base_flat, bar_size_flat;

    always #10 clk = ~clk;

    cfg_header_regfile #(
        .BAR_INIT (B_INIT), .BAR_SIZE (B_SIZE), .BAR_LEGACY (B_LEG), .RSP_LAT (LAT)
    ) u_cfg_header_regfile (
        .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_size, .req_write,
        .req_wdata, .rsp_valid, .rsp_rdata, .rsp_error, .hit_addr, .hit_onehot,
        .bar_base_flat, .bar_size_flat
    );

    int n_checks = 0, n_errors = 0;
    bit done = 1'b0;

    logic [15:0] m_cmd = 16'h0000, m_stat = 16'h0210;
    logic [7:0]  m_cls = 8'h00, m_lat = 8'h00, m_intl = 8'h0B;
    logic [31:0] m_rom = 32'h0;
    logic [31:0] m_bar [6];
    logic [31:0] m_dec [6];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mdword(input int w);
        case (w)
            0:  return {16'h7A31, 16'hC0DE};
            1:  return {m_stat, m_cmd};
            2:  return {8'h02, 8'h06, 8'h01, 8'h05};
            3:  return {8'h00, 8'h00, m_lat, m_cls};
            4, 5, 6, 7, 8, 9: return B_LEG[w-4] ? 32'd0 : m_bar[w-4];
            11: return {16'h0102, 16'hABCD};
            12: return m_rom;
            15: return {8'h20, 8'h10, 8'h01, m_intl};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] mread(input logic [7:0] off, input logic [2:0] sz);
        logic [31:0] r = '0;
        for (int k = 0; k < sz; k++) begin
            int i = int'(off) + k;
            if (i < 64) r[8*k +: 8] = mdword(i / 4)[8*(i%4) +: 8];
        end
        return r;
    endfunction

    function automatic bit merr(input bit wr, input logic [7:0] off, input logic [2:0] sz);
        if (!(sz == 1 || sz == 2 || sz == 4)) return 1'b1;
        if (off >= 8'h40) return 1'b1;
        if (!wr) return 1'b0;
        if (sz == 1) return !(off inside {8'h3C, 8'h0C, 8'h0D, 8'h08, 8'h0B, 8'h3D, 8'h3E, 8'h3F});
        if (sz == 2) return !(off inside {8'h04, 8'h06, 8'h0C});
        return 1'b0;
    endfunction

    function automatic string mtag(input bit wr, input logic [7:0] off, input logic [2:0] sz, input logic [31:0] d);
        if (!(sz == 1 || sz == 2 || sz == 4)) return "R3";
        if (off >= 8'h40) return "R2";
        if (!wr) return "R1";
        if (sz == 1) return "R5";
        if (sz == 2) return "R6";
        if (off >= 8'h10 && off < 8'h28 && off[1:0] == 2'b00) begin
            if (B_LEG[(off - 8'h10) >> 2]) return "R10";
            return (d == 32'hFFFF_FFFF) ? "R8" : "R9";
        end
        if (off == 8'h30) return "R11";
        return "R7";
    endfunction

    task automatic mwrite(input logic [7:0] off, input logic [2:0] sz, input logic [31:0] d);
        if (sz == 1) begin
            if (off == 8'h3C) m_intl = d[7:0];
            if (off == 8'h0C) m_cls  = d[7:0];
            if (off == 8'h0D) m_lat  = d[7:0];
        end else if (sz == 2) begin
            if (off == 8'h04) m_cmd  = d[15:0];
            if (off == 8'h06) m_stat = d[15:0];
            if (off == 8'h0C) m_cls  = d[7:0];
        end else begin
            if (off == 8'h04) m_cmd = d[15:0];
            if (off == 8'h30) m_rom = (d == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : d;
            for (int i = 0; i < 6; i++) begin
                if (off == 8'(16 + 4*i) && !B_LEG[i]) begin
                    logic [31:0] old = m_bar[i];
                    logic [31:0] msk = old[0] ? 32'h3 : 32'hF;
                    logic [31:0] nv;
                    if (d == 32'hFFFF_FFFF) nv = ~(B_SIZE[32*i +: 32] - 32'd1);
                    else begin
                        nv = d & ~msk;
                        if (nv != 0) m_dec[i] = nv;
                    end
                    m_bar[i] = (nv & ~msk) | (old & msk);
                end
            end
        end
    endtask

    function automatic logic [5:0] mhit(input logic [31:0] a);
        for (int i = 0; i < 6; i++) begin
            logic [31:0] sz = B_SIZE[32*i +: 32];
            if (!B_LEG[i] && sz != 0 && m_dec[i] != 0 && a >= m_dec[i] && (a - m_dec[i]) < sz)
                return 6'(1) << i;
        end
        return 6'd0;
    endfunction

    task automatic xact(input bit wr, input logic [7:0] off, input logic [2:0] sz,
                        input logic [31:0] d, output logic [31:0] rd, output bit er, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = off; req_size = sz; req_wdata = d;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && lat < 40) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        rd = rsp_rdata; er = rsp_error;
    endtask

    task automatic op(input bit wr, input logic [7:0] off, input logic [2:0] sz, input logic [31:0] d);
        logic [31:0] rd, erd;
        bit er, eer;
        int lat;
        string tg;
        tg  = mtag(wr, off, sz, d);
        eer = merr(wr, off, sz);
        erd = (wr || eer) ? 32'd0 : mread(off, sz);
        xact(wr, off, sz, d, rd, er, lat);
        check(er == eer, {tg, " error flag"}, 32'(er), 32'(eer));
        if (!wr) check(rd == erd, {tg, " read data"}, rd, erd);
        // R4 latency
        check(lat == LAT, "R4 latency", 32'(lat), 32'(LAT));
        if (wr && !eer) begin
            logic [7:0] aoff;
            mwrite(off, sz, d);
            aoff = {off[7:2], 2'b00};
            erd  = mread(aoff, 3'd4);
            xact(1'b0, aoff, 3'd4, 32'd0, rd, er, lat);
            check(rd == erd, {tg, " readback"}, rd, erd);
        end
    endtask

    task automatic hit_probe(input logic [31:0] a);
        logic [5:0] e;
        @(negedge clk);
        hit_addr = a;
        #1;
        e = mhit(a);
        check(hit_onehot == e, "R12 hit", 32'(hit_onehot), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] pool [16] = '{8'h00, 8'h04, 8'h06, 8'h08, 8'h0B, 8'h0C, 8'h0D, 8'h10,
                                  8'h14, 8'h18, 8'h1C, 8'h30, 8'h3C, 8'h3D, 8'h3E, 8'h40};
        logic [31:0] rd;
        bit er;
        int lat;
        void'($urandom(32'd4242));
        for (int i = 0; i < 6; i++) begin
            m_bar[i] = B_INIT[32*i +: 32];
            m_dec[i] = 32'd0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset contents of every dword
        for (int w = 0; w < 16; w++) op(1'b0, 8'(4*w), 3'd4, 32'd0);
        // R1 unaligned reads including past the header end
        op(1'b0, 8'h3E, 3'd4, 0);
        op(1'b0, 8'h01, 3'd2, 0);
        op(1'b0, 8'h0B, 3'd1, 0);
        // R2 R3 corner cases
        op(1'b0, 8'h40, 3'd4, 0);
        op(1'b1, 8'hFC, 3'd4, 32'h1234_5678);
        op(1'b0, 8'h00, 3'd3, 0);
        op(1'b1, 8'h04, 3'd0, 32'hFFFF);
        // R8 probes on memory, IO and size-zero BARs
        op(1'b1, 8'h10, 3'd4, 32'hFFFF_FFFF);
        op(1'b1, 8'h14, 3'd4, 32'hFFFF_FFFF);
        op(1'b1, 8'h20, 3'd4, 32'hFFFF_FFFF);
        // R10 legacy BAR
        op(1'b1, 8'h1C, 3'd4, 32'h0000_5000);
        // R11 ROM probe and plain write
        op(1'b1, 8'h30, 3'd4, 32'hFFFF_FFFE);
        op(1'b1, 8'h30, 3'd4, 32'hFFFF_FFFD);
        // R5 dropped byte writes and a rejected one
        op(1'b1, 8'h3D, 3'd1, 32'h77);
        op(1'b1, 8'h08, 3'd1, 32'h77);
        op(1'b1, 8'h00, 3'd1, 32'h77);
        // R7 dropped 32-bit write, command write leaves status
        op(1'b1, 8'h2C, 3'd4, 32'hDEAD_BEEF);
        op(1'b1, 8'h04, 3'd4, 32'hA5A5_0147);
        // R9 zero write keeps decode base at zero
        op(1'b1, 8'h10, 3'd4, 32'h0000_0000);
        hit_probe(32'h0000_0010);

        // R12 same-cycle BAR write and hit lookup
        begin
            logic [5:0] e_old, e_new;
            @(negedge clk);
            while (!req_ready) @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h10; req_size = 3'd4;
            req_wdata = 32'h4000_0000; hit_addr = 32'h4000_0FFF;
            #1;
            e_old = mhit(hit_addr);
            check(hit_onehot == e_old, "R12 old window in write cycle", 32'(hit_onehot), 32'(e_old));
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            mwrite(8'h10, 3'd4, 32'h4000_0000);
            e_new = mhit(hit_addr);
            check(hit_onehot == e_new && e_new == 6'b000001, "R12 new window after edge",
                  32'(hit_onehot), 32'(6'b000001));
            xact(1'b0, 8'h00, 3'd4, 0, rd, er, lat);
        end
        op(1'b1, 8'h18, 3'd4, 32'h4000_0000);
        // R12 overlap resolves to lowest index, then upper window only, then miss
        hit_probe(32'h4000_0000);
        hit_probe(32'h4000_1000);
        hit_probe(32'h4010_0000);
        op(1'b1, 8'h14, 3'd4, 32'h0000_C001);
        hit_probe(32'h0000_C0FF);
        hit_probe(32'h0000_C100);

        // random phase
        for (int n = 0; n < 400; n++) begin
            bit wr = $urandom_range(0, 1) == 1;
            logic [7:0] off;
            logic [2:0] sz;
            logic [31:0] d;
            int pick;
            off = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 71)) : pool[$urandom_range(0, 15)];
            pick = $urandom_range(0, 9);
            sz = (pick < 3) ? 3'd4 : (pick < 6) ? 3'd2 : (pick < 8) ? 3'd1 : 3'($urandom_range(0, 7));
            pick = $urandom_range(0, 7);
            d = (pick < 2) ? 32'hFFFF_FFFF : (pick == 2) ? 32'hFFFF_FFFE : $urandom;
            op(wr, off, sz, d);
            begin
                int j = $urandom_range(0, 5);
                logic [31:0] span = B_SIZE[32*j +: 32] * 2 + 1;
                hit_probe(m_dec[j] + $urandom_range(0, int'(span[15:0])));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule